// File: doc/BRIEF.md
# Bi-quinary timer port generator

This block turns the sound-processor clock into a slow time base that software can poll. A prescaler counts 512 enabled clock cycles and then advances a ten-phase sequencer, so one full sequencer cycle spans 5120 enabled clocks. The sequencer counts in bi-quinary order: a two-state digit in the low bit and a five-state digit above it. Its phase is decoded onto four bits of an 8-bit port, and a software loop that reads the port sees the upper nibble step through a fixed pattern.

Two board variants are supported through the `BOARD_MAP` parameter. They differ in where one decoded tap appears: bit 5 in variant 0, bit 3 in variant 1. A synchronous reset clears both counting stages. The clock-enable input gates every count, so the whole time base freezes while it is low.

Sequencer states are `PH_0` through `PH_9`. The named transitions are `PH_n -> PH_n+1` on each prescaler tick for n from 0 to 8, the wrap `PH_9 -> PH_0` on a tick, a self-loop with no tick, and any state to `PH_0` on reset.

Top module: `biq_timer_port`

## Requirements
- R1: While `rst_i` is high at a rising edge, the port reads 0x00 after that edge and the prescaler is cleared. The first phase step after reset comes only after exactly 512 enabled clocks.
- R2: The phase advances by exactly one step on the rising edge that completes every 512th enabled clock, and at no other time.
- R3: At an edge where `ce_i` is low, neither the prescaler nor the phase changes, so the port holds its value.
- R4: After phase 9 the next step returns to phase 0, giving a period of 5120 enabled clocks.
- R5: Port bit 4 reads 1 exactly in odd phases, so it alternates on every phase step.
- R6: With `BOARD_MAP`=0, phases 0 to 9 read 0x00, 0x10, 0x20, 0x30, 0x40, 0x90, 0xA0, 0xB0, 0xA0, 0xD0.
- R7: With `BOARD_MAP`=1, phases 0 to 9 read 0x00, 0x10, 0x08, 0x18, 0x40, 0x90, 0x88, 0x98, 0x88, 0xD0.
- R8: Port bits 2..0 always read 0. Bit 3 always reads 0 when `BOARD_MAP`=0, and bit 5 always reads 0 when `BOARD_MAP`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sound-processor clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Count enable; every stage holds while it is low |
| port_o | output | 8 | Decoded timer phase, read-back value |

## Verification
A corrupt prescaler count moves the next phase step away from its 512-clock boundary. That error shows up on the port at the first step after the fault, at most 512 enabled clocks later. A sequencer that skips a state or leaves the legal encodings breaks the pattern in R6/R7 at its next tick, and the bit-4 alternation shows it on the same edge. A mis-wired mapping shows immediately, because every vector compares the full port byte for both variants.

// File: rtl/biq_pkg.sv
package biq_pkg;

    // Bi-quinary encoding: bit 0 is the binary digit, bits 3..1 the quinary digit
    typedef enum logic [3:0] {
        PH_0 = 4'b0000,
        PH_1 = 4'b0001,
        PH_2 = 4'b0010,
        PH_3 = 4'b0011,
        PH_4 = 4'b0100,
        PH_5 = 4'b0101,
        PH_6 = 4'b0110,
        PH_7 = 4'b0111,
        PH_8 = 4'b1000,
        PH_9 = 4'b1001
    } phase_t;

    // Decoded taps before they are placed on the port
    typedef struct packed {
        logic top;   // high in the upper five phases
        logic mark;  // high in phases 4 and 9
        logic sel;   // variant-placed tap
        logic half;  // divide-by-1024 output
    } taps_t;

endpackage

// File: rtl/biq_prescaler.sv
module biq_prescaler #(
    parameter int DIV = 512
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ce_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = ce_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (ce_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/biq_sequencer.sv
module biq_sequencer
    import biq_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  tick_i,
    output taps_t taps_o
);
    phase_t state_q, state_d;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PH_0;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state: advance on tick, wrap after PH_9
    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            unique case (state_q)
                PH_0:    state_d = PH_1;
                PH_1:    state_d = PH_2;
                PH_2:    state_d = PH_3;
                PH_3:    state_d = PH_4;
                PH_4:    state_d = PH_5;
                PH_5:    state_d = PH_6;
                PH_6:    state_d = PH_7;
                PH_7:    state_d = PH_8;
                PH_8:    state_d = PH_9;
                PH_9:    state_d = PH_0;
                default: state_d = PH_0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        taps_o = '0;
        unique case (state_q)
            PH_0:    taps_o = '{top: 1'b0, mark: 1'b0, sel: 1'b0, half: 1'b0};
            PH_1:    taps_o = '{top: 1'b0, mark: 1'b0, sel: 1'b0, half: 1'b1};
            PH_2:    taps_o = '{top: 1'b0, mark: 1'b0, sel: 1'b1, half: 1'b0};
            PH_3:    taps_o = '{top: 1'b0, mark: 1'b0, sel: 1'b1, half: 1'b1};
            PH_4:    taps_o = '{top: 1'b0, mark: 1'b1, sel: 1'b0, half: 1'b0};
            PH_5:    taps_o = '{top: 1'b1, mark: 1'b0, sel: 1'b0, half: 1'b1};
            PH_6:    taps_o = '{top: 1'b1, mark: 1'b0, sel: 1'b1, half: 1'b0};
            PH_7:    taps_o = '{top: 1'b1, mark: 1'b0, sel: 1'b1, half: 1'b1};
            PH_8:    taps_o = '{top: 1'b1, mark: 1'b0, sel: 1'b1, half: 1'b0};
            PH_9:    taps_o = '{top: 1'b1, mark: 1'b1, sel: 1'b0, half: 1'b1};
            default: taps_o = '0;
        endcase
    end
endmodule

// File: rtl/biq_port_map.sv
module biq_port_map
    import biq_pkg::*;
#(
    parameter int BOARD_MAP = 0
) (
    input  taps_t      taps_i,
    output logic [7:0] port_o
);
    generate
        if (BOARD_MAP == 0) begin : g_map_hi
            assign port_o = {taps_i.top, taps_i.mark, taps_i.sel, taps_i.half, 4'b0000};
        end else begin : g_map_lo
            assign port_o = {taps_i.top, taps_i.mark, 1'b0, taps_i.half, taps_i.sel, 3'b000};
        end
    endgenerate
endmodule

// File: rtl/biq_timer_port.sv
module biq_timer_port
    import biq_pkg::*;
#(
    parameter int PRESCALE  = 512,
    parameter int BOARD_MAP = 0
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ce_i,
    output logic [7:0] port_o
);
    logic  tick;
    taps_t taps;

    biq_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ce_i   (ce_i),
        .tick_o (tick)
    );

    biq_sequencer u_seq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick),
        .taps_o (taps)
    );

    biq_port_map #(.BOARD_MAP(BOARD_MAP)) u_map (
        .taps_i (taps),
        .port_o (port_o)
    );
endmodule

// File: rtl/biq_timer_port_chk.sv
module biq_timer_port_chk #(
    parameter int PRESCALE  = 512,
    parameter int BOARD_MAP = 0
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       ce_i,
    input logic [7:0] port_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
    localparam logic [7:0] DEAD = (BOARD_MAP == 0) ? 8'h0F : 8'h27;

    // Independent enabled-clock counter for the window check
    logic [CW-1:0] seen_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)            seen_q <= '0;
        else if (ce_i)        seen_q <= (seen_q == LAST) ? '0 : seen_q + 1'b1;
    end

    assert_reset_zero_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> port_o == 8'h00);

    assert_step_window_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$stable(port_o)) |-> ($past(ce_i) && $past(seen_q) == LAST));

    assert_hold_disabled_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(ce_i) && !$past(rst_i)) |-> $stable(port_o));

    assert_half_toggle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$stable(port_o)) |-> port_o[4] != $past(port_o[4]));

    assert_dead_bits_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (port_o & DEAD) == 8'h00);
endmodule

bind biq_timer_port biq_timer_port_chk #(
    .PRESCALE  (PRESCALE),
    .BOARD_MAP (BOARD_MAP)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .ce_i   (ce_i),
    .port_o (port_o)
);

// File: tb/biq_timer_port_bench.sv
module biq_timer_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 512;

    typedef struct {
        logic [7:0] exp_a;
        logic [7:0] exp_b;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b0;
    logic [7:0] port_a, port_b;

    int   vectors = 0;
    int   fails = 0;
    int   mcnt = 0;
    int   mph = 0;
    bit   done = 1'b0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    biq_timer_port #(.PRESCALE(DIV), .BOARD_MAP(0)) u_biq_timer_port (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .port_o(port_a));

    biq_timer_port #(.PRESCALE(DIV), .BOARD_MAP(1)) u_biq_timer_port_b (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .port_o(port_b));

    // R6 table
    function automatic logic [7:0] val_a(int ph);
        case (ph)
            0: return 8'h00;  1: return 8'h10;  2: return 8'h20;  3: return 8'h30;
            4: return 8'h40;  5: return 8'h90;  6: return 8'hA0;  7: return 8'hB0;
            8: return 8'hA0;  default: return 8'hD0;
        endcase
    endfunction

    // R7 table
    function automatic logic [7:0] val_b(int ph);
        case (ph)
            0: return 8'h00;  1: return 8'h10;  2: return 8'h08;  3: return 8'h18;
            4: return 8'h40;  5: return 8'h90;  6: return 8'h88;  7: return 8'h98;
            8: return 8'h88;  default: return 8'hD0;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle, update model, push expectation
    task automatic step(bit r, bit e, string tag);
        item_t it;
        @(negedge clk);
        rst = r;
        ce  = e;
        @(posedge clk);
        #1;
        if (r) begin
            mcnt = 0;
            mph  = 0;
        end else if (e) begin
            if (mcnt == DIV - 1) begin
                mcnt = 0;
                mph  = (mph + 1) % 10;
            end else begin
                mcnt++;
            end
        end
        it.exp_a = val_a(mph);
        it.exp_b = val_b(mph);
        it.tag   = tag;
        sb.push_back(it);
    endtask

    // Monitor
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " R6 variant0"}, port_a, it.exp_a);
            check({it.tag, " R7 variant1"}, port_b, it.exp_b);
            check("R5 bit4", {7'b0, port_a[4]}, {7'b0, it.exp_a[4]});
            check("R8 dead bits", (port_a & 8'h0F) | (port_b & 8'h27), 8'h00);
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R1");
        // R2: continuous counting through all phases
        for (int i = 0; i < 10 * DIV; i++) step(1'b0, 1'b1, "R2");
        // R4: wrap back to phase 0 and onward
        for (int i = 0; i < DIV + 100; i++) step(1'b0, 1'b1, "R4");
        // R3: alternating enable, then a long hold
        for (int i = 0; i < 1500; i++) step(1'b0, i[0], "R3");
        for (int i = 0; i < 700; i++) step(1'b0, 1'b0, "R3");
        for (int i = 0; i < 3 * DIV; i++) step(1'b0, 1'b1, "R2");
        // R1: mid-count reset, first step exactly 512 clocks later
        step(1'b1, 1'b1, "R1");
        for (int i = 0; i < DIV + 8; i++) step(1'b0, 1'b1, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule